// File: doc/BRIEF.md
# Lockable Flash Address-Range Protector

This block sits on the path from a host to a serial flash controller and rules on every flash access before it reaches the memory. Software programs up to four address windows. Each window has a 2 kB-aligned base, a size counted in whole kilobytes, and separate flags that block reads and block writes. A control register arms checking. A sticky lock bit in the same register freezes the whole configuration until the next reset, so code that runs later cannot lift the protection.

Each access is a 24-bit byte address, a read or write type and a valid strobe. The verdict is registered and appears one clock after the strobe. A refused read has its data replaced with the value of erased flash. A refused write is dropped and produces a one-cycle violation pulse.

Top module: `flash_guard`

## Requirements
- R1: After reset, all region registers and the control register read 0, and no response or violation is signalled.
- R2: Configuration index 0 to 3 selects region registers 0 to 3, and index 4 selects the control register. Region registers read back exactly as written. In the control register, bit 0 is the enable and bit 1 is the lock, and all other bits read 0.
- R3: Region word layout: bit 0 write-block, bit 1 read-block, bits [10:2] size S, bits [31:11] base bits. The region covers base through base + (S+1)*1024 - 1, both ends inclusive. With base 0x5FF800 and S = 0x1FF, 0x5FF800 and 0x67F7FF are inside the region, and 0x5FF7FF and 0x67F800 are outside it.
- R4: When enabled, a write that falls in any region with write-block set is denied. A region that has only write-block set does not affect reads.
- R5: When enabled, a read that falls in any region with read-block set is denied. A region that has only read-block set does not affect writes.
- R6: With the enable at 0, every access is allowed, whatever the regions hold.
- R7: Once the lock is 1, configuration writes to any index change nothing, and the lock stays at 1 until reset.
- R8: On a denied read, the response data is 0xFF. On an allowed read, it is flash_rdata_i.
- R9: viol_o is high for exactly the one response cycle of a denied write. It never rises for reads or for allowed writes.
- R10: resp_valid_o is high exactly one clock after a clock in which acc_valid_i was high, and low otherwise.
- R11: Overlapping regions combine by OR: a denial from any region that covers the address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read-back of the indexed register (combinational) |
| acc_valid_i | input | 1 | Access request strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 24 | Flash byte address |
| flash_rdata_i | input | 8 | Read data from the flash controller |
| resp_valid_o | output | 1 | Verdict valid, one cycle after the request |
| resp_allow_o | output | 1 | 1 = access allowed |
| resp_rdata_o | output | 8 | Read data, 0xFF if the read was denied |
| viol_o | output | 1 | One-cycle pulse on a denied write |

## Verification
The bench probes both ends of a 512 kB window, plus the byte just outside each end. An off-by-one in the end computation, or a size field misread as bytes, shows up there as a wrong verdict. Regions with only one of the two flags set catch a design that crosses the read and write flags. Overlapping regions with different flags catch a design that lets one region's answer override another's. After locking, the bench attempts to clear both the control register and a region. A lock that is not sticky, or that guards only the control register, shows up as changed read-back or as an access that is now allowed. A reset follows to show that only reset releases the lock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int WORD_W     = 32;
  localparam int SIZE_W     = 9;
  localparam int BASE_LSB   = 11;
  localparam int GRAN_SHIFT = 10;

  // field order mirrors the register bit layout, msb first
  typedef struct packed {
    logic [WORD_W-1-BASE_LSB:0] base;
    logic [SIZE_W-1:0]          size;
    logic                       rd_block;
    logic                       wr_block;
  } region_t;
endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int IDX_W     = $clog2(N_REGIONS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic [WORD_W-1:0]          cfg_wdata_i,
  output logic [WORD_W-1:0]          cfg_rdata_o,
  output region_t [N_REGIONS-1:0]    regions_o,
  output logic                       en_o,
  output logic                       lock_o
);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(N_REGIONS);

  logic [N_REGIONS-1:0][WORD_W-1:0] region_q;
  logic en_q, lock_q;
  logic wr_ok;

  assign wr_ok = cfg_we_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < N_REGIONS; i++)
        if (cfg_idx_i == IDX_W'(i)) region_q[i] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_ok && cfg_idx_i == CTRL_IDX) begin
      en_q   <= cfg_wdata_i[0];
      lock_q <= cfg_wdata_i[1];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < N_REGIONS; i++)
      if (cfg_idx_i == IDX_W'(i)) cfg_rdata_o = region_q[i];
    if (cfg_idx_i == CTRL_IDX) cfg_rdata_o = WORD_W'({lock_q, en_q});
  end

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_out
    assign regions_o[g] = region_t'(region_q[g]);
  end

  assign en_o   = en_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/flash_guard_match.sv
module flash_guard_match
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  region_t           region_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_block_o,
  output logic              wr_block_o
);
  // one spare bit so base + span never wraps
  localparam int CMP_W = WORD_W + 1;

  logic [CMP_W-1:0] lo, span, hi, a;
  logic hit;

  assign lo   = CMP_W'({region_i.base, {BASE_LSB{1'b0}}});
  assign span = (CMP_W'(region_i.size) + CMP_W'(1)) << GRAN_SHIFT;
  assign hi   = lo + span;
  assign a    = CMP_W'(addr_i);
  assign hit  = (a >= lo) && (a < hi);

  assign rd_block_o = hit && region_i.rd_block;
  assign wr_block_o = hit && region_i.wr_block;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(N_REGIONS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic              resp_valid_o,
  output logic              resp_allow_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              viol_o
);
  region_t [N_REGIONS-1:0]      regions;
  logic [N_REGIONS*WORD_W-1:0]  region_flat;
  logic                         ctrl_en, ctrl_lock;
  logic [N_REGIONS-1:0]         rd_hit, wr_hit;
  logic                         deny_d;
  logic                         valid_q, allow_q, write_q;

  flash_guard_regs #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .regions_o   (regions),
    .en_o        (ctrl_en),
    .lock_o      (ctrl_lock)
  );

  assign region_flat = regions;

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_match
    flash_guard_match #(.ADDR_W(ADDR_W)) u_match (
      .region_i   (regions[g]),
      .addr_i     (acc_addr_i),
      .rd_block_o (rd_hit[g]),
      .wr_block_o (wr_hit[g])
    );
  end

  // any covering region with the matching flag denies
  assign deny_d = ctrl_en && (acc_write_i ? |wr_hit : |rd_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      write_q <= 1'b0;
      viol_o  <= 1'b0;
    end else begin
      valid_q <= acc_valid_i;
      allow_q <= acc_valid_i && !deny_d;
      write_q <= acc_valid_i && acc_write_i;
      viol_o  <= acc_valid_i && acc_write_i && deny_d;
    end
  end

  assign resp_valid_o = valid_q;
  assign resp_allow_o = allow_q;
  assign resp_rdata_o = (valid_q && !allow_q && !write_q) ? {DATA_W{1'b1}} : flash_rdata_i;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int N_REGIONS = 4,
  parameter int DATA_W    = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    acc_valid_i,
  input logic                    acc_write_i,
  input logic                    resp_valid_o,
  input logic                    resp_allow_o,
  input logic [DATA_W-1:0]       resp_rdata_o,
  input logic                    viol_o,
  input logic                    ctrl_en,
  input logic                    ctrl_lock,
  input logic [N_REGIONS*32-1:0] region_flat
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !resp_valid_o && !viol_o && !ctrl_lock && !ctrl_en);

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> resp_valid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !resp_valid_o);

  a_r6_disabled_allows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !ctrl_en |=> resp_allow_o);

  a_r9_viol_is_denial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> resp_valid_o && !resp_allow_o);

  a_r9_no_viol_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i |=> !viol_o);

  a_r8_denied_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_allow_o && !viol_o |-> resp_rdata_o == {DATA_W{1'b1}});

  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_lock |=> ctrl_lock);

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_lock |=> $stable(region_flat) && $stable(ctrl_en));
endmodule

bind flash_guard flash_guard_chk #(.N_REGIONS(N_REGIONS), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .resp_valid_o (resp_valid_o),
  .resp_allow_o (resp_allow_o),
  .resp_rdata_o (resp_rdata_o),
  .viol_o       (viol_o),
  .ctrl_en      (ctrl_en),
  .ctrl_lock    (ctrl_lock),
  .region_flat  (region_flat)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam logic [7:0] FDATA = 8'h5A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [23:0] acc_addr_i = '0;
  logic [7:0]  flash_rdata_i = FDATA;
  logic        resp_valid_o, resp_allow_o, viol_o;
  logic [7:0]  resp_rdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_guard uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic cfg_chk(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk_i); cfg_idx_i = idx;
    #1 chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic access(input logic wr, input logic [23:0] a, input logic exp_allow, input string tag);
    @(negedge clk_i); acc_valid_i = 1'b1; acc_write_i = wr; acc_addr_i = a;
    @(posedge clk_i); #1;
    chk({tag, " R10 valid"}, 32'(resp_valid_o), 32'd1);
    chk({tag, " allow"}, 32'(resp_allow_o), 32'(exp_allow));
    chk({tag, " R9 viol"}, 32'(viol_o), 32'(wr && !exp_allow));
    if (!wr) chk({tag, " R8 rdata"}, 32'(resp_rdata_o), exp_allow ? 32'(FDATA) : 32'hFF);
    @(negedge clk_i); acc_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk({tag, " R10 idle"}, 32'(resp_valid_o), 32'd0);
    chk({tag, " R9 pulse ends"}, 32'(viol_o), 32'd0);
  endtask

  task automatic t_reset(input string tag);
    @(posedge clk_i); #1;
    chk({tag, " R1 valid"}, 32'(resp_valid_o), 32'd0);
    chk({tag, " R1 viol"}, 32'(viol_o), 32'd0);
    for (int i = 0; i < 5; i++) cfg_chk(3'(i), 32'd0, {tag, " R1 regs"});
  endtask

  task automatic t_readback();
    cfg_wr(3'd0, 32'hA5C3_17FE);
    cfg_chk(3'd0, 32'hA5C3_17FE, "R2 region0 readback");
    cfg_wr(3'd3, 32'h0123_4567);
    cfg_chk(3'd3, 32'h0123_4567, "R2 region3 readback");
    cfg_wr(3'd4, 32'hFFFF_FFFD);
    cfg_chk(3'd4, 32'h0000_0001, "R2 ctrl readback");
    cfg_wr(3'd4, 32'h0);
  endtask

  task automatic t_disabled();
    cfg_wr(3'd0, 32'h0000_07FF);  // base 0, 512 kB, both flags
    access(1'b1, 24'h000100, 1'b1, "R6 write disabled");
    access(1'b0, 24'h000100, 1'b1, "R6 read disabled");
  endtask

  task automatic t_span();
    cfg_wr(3'd1, 32'h005F_FFFF);  // base 0x5FF800, 512 kB, both flags
    cfg_wr(3'd3, 32'h0);
    cfg_wr(3'd4, 32'h1);
    access(1'b0, 24'h5FF800, 1'b0, "R3 R5 low edge");
    access(1'b0, 24'h67F7FF, 1'b0, "R3 R5 high edge");
    access(1'b0, 24'h67F800, 1'b1, "R3 past end");
    access(1'b0, 24'h5FF7FF, 1'b1, "R3 before base");
    access(1'b1, 24'h07FFFF, 1'b0, "R3 R4 region0 end");
    access(1'b1, 24'h080000, 1'b1, "R3 region0 past end");
  endtask

  task automatic t_write_only();
    cfg_wr(3'd2, 32'h0010_0001);  // base 0x100000, 1 kB, write-block
    access(1'b1, 24'h100000, 1'b0, "R4 wp write");
    access(1'b0, 24'h100000, 1'b1, "R4 wp read passes");
    access(1'b1, 24'h1003FF, 1'b0, "R4 wp last byte");
    access(1'b1, 24'h100400, 1'b1, "R4 wp past end");
  endtask

  task automatic t_read_only();
    cfg_wr(3'd3, 32'h0020_000E);  // base 0x200000, 4 kB, read-block
    access(1'b0, 24'h200FFF, 1'b0, "R5 rp read");
    access(1'b1, 24'h200FFF, 1'b1, "R5 rp write passes");
    access(1'b0, 24'h201000, 1'b1, "R5 rp past end");
  endtask

  task automatic t_overlap();
    cfg_wr(3'd2, 32'h0020_0801);  // base 0x200800, 1 kB, write-block
    access(1'b1, 24'h200800, 1'b0, "R11 overlap write");
    access(1'b0, 24'h200800, 1'b0, "R11 overlap read");
    access(1'b1, 24'h200C00, 1'b1, "R11 outer only write");
    access(1'b0, 24'h200C00, 1'b0, "R11 outer only read");
  endtask

  task automatic t_lock();
    cfg_wr(3'd4, 32'h3);
    cfg_chk(3'd4, 32'h3, "R7 locked ctrl");
    cfg_wr(3'd4, 32'h0);
    cfg_chk(3'd4, 32'h3, "R7 ctrl clear ignored");
    cfg_wr(3'd1, 32'h0);
    cfg_chk(3'd1, 32'h005F_FFFF, "R7 region clear ignored");
    access(1'b0, 24'h5FF800, 1'b0, "R7 still denied");
    do_reset();
    cfg_chk(3'd4, 32'h0, "R7 R1 reset unlocks");
    cfg_chk(3'd1, 32'h0, "R1 region after reset");
    access(1'b0, 24'h5FF800, 1'b1, "R1 allowed after reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    t_reset("start");
    t_readback();
    t_disabled();
    t_span();
    t_write_only();
    t_read_only();
    t_overlap();
    t_lock();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule